// File: doc/BRIEF.md
# Packet Duplicator with Destination Rewrite

This block sits between a mesh router's output and the local network interface of a node that takes part in dual-modular-redundant execution. Every flit that arrives for the node goes to local delivery. When the node is set up as the master of a pair, each packet is also written into a dedicated copy store. In that copy, the destination coordinate of the head flit is replaced by the partner (mirror) node's X/Y coordinate. The copy store then injects the packet back into the mesh, so that both nodes of the pair consume identical data.

The node role and the partner coordinate sit in a small configuration register that software writes. The role is sampled once per packet, on its head flit, so a packet is never split between copied and uncopied flits. The input side accepts a flit only when local delivery and, for a copied packet, the copy store can both take it. This keeps the two output streams flit-for-flit identical.

Top module: `pkt_fork_top`

## Requirements
- R1: After reset, loc_valid and cpy_valid are 0, in_ready is 1, and the role is normal (no copying).
- R2: Every accepted flit appears on the local stream unchanged, in order, with its last flag, whatever the role.
- R3: In master role (cfg_role = 1), the copy of a head flit carries the mirror X in bits [7:4] and the mirror Y in bits [3:0], with bits [31:8] unchanged. A head flit is the first accepted flit after reset or after a flit with last = 1.
- R4: Body flits of a copied packet reach the copy stream unchanged and in order, with the last flag preserved.
- R5: In normal (0), mirror (2) or reserved (3) role, no flit reaches the copy stream and local delivery is unaffected.
- R6: A flit is accepted only when the local output stage can take it and, for a copied packet, the copy store has room. While local delivery is stalled, nothing further enters either stream.
- R7: The copy store holds 16 flits behind a one-flit output register. With cpy_ready low, exactly 17 flits of a copied packet are accepted, then in_ready drops, and no flit is lost once cpy_ready rises.
- R8: The role in force when a packet's head flit is accepted governs the whole packet. A role change in mid-packet applies from the next head flit.
- R9: With empty stages and both ready inputs high, a flit accepted at clock edge t is on loc_data after edge t and on cpy_data after edge t+1.
- R10: A configuration write at edge t applies to a head flit accepted at any edge after t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_role | input | 2 | Role: 0 normal, 1 master, 2 mirror, 3 reserved |
| cfg_mx | input | 4 | Partner X coordinate |
| cfg_my | input | 4 | Partner Y coordinate |
| in_valid | input | 1 | Incoming flit valid |
| in_data | input | 32 | Incoming flit |
| in_last | input | 1 | Incoming flit ends its packet |
| in_ready | output | 1 | Flit accepted when high with in_valid |
| loc_valid | output | 1 | Local flit valid |
| loc_data | output | 32 | Local flit |
| loc_last | output | 1 | Local flit ends its packet |
| loc_ready | input | 1 | Local sink ready |
| cpy_valid | output | 1 | Copy flit valid |
| cpy_data | output | 32 | Copy flit, head rewritten |
| cpy_last | output | 1 | Copy flit ends its packet |
| cpy_ready | input | 1 | Mesh injection ready |

## Verification
A local flit is due one edge after acceptance. A copy flit is due two edges after acceptance when the copy store is empty, because it passes through the storage array and then the output register. The bench drives inputs one time unit after a rising edge and samples at the falling edge, so every handshake is seen in the half-cycle before the edge that completes it. The latency scenario checks loc_valid at the first falling edge after acceptance and cpy_valid only at the second. Monitors capture each completed handshake, and the drained streams are compared flit by flit against expected queues built from the requirements. The stall scenarios count accepted flits at falling edges.

// File: rtl/pkt_fork_pkg.sv
package pkt_fork_pkg;
  typedef enum logic [1:0] {
    ROLE_NORMAL = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_MIRROR = 2'd2,
    ROLE_RSVD   = 2'd3
  } role_t;
endpackage

// File: rtl/pkt_fork_cfg.sv
module pkt_fork_cfg #(
  parameter int COORD_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [1:0]           role_in,
  input  logic [COORD_W-1:0]   mx_in,
  input  logic [COORD_W-1:0]   my_in,
  output pkt_fork_pkg::role_t  role,
  output logic [COORD_W-1:0]   mx,
  output logic [COORD_W-1:0]   my
);
  always_ff @(posedge clk) begin
    if (rst) begin
      role <= pkt_fork_pkg::ROLE_NORMAL;
      mx   <= '0;
      my   <= '0;
    end else if (we) begin
      role <= pkt_fork_pkg::role_t'(role_in);
      mx   <= mx_in;
      my   <= my_in;
    end
  end
endmodule

// File: rtl/pkt_fork_ctrl.sv
module pkt_fork_ctrl #(
  parameter int FLIT_W  = 32,
  parameter int COORD_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pkt_fork_pkg::role_t  role,
  input  logic [COORD_W-1:0]   mx,
  input  logic [COORD_W-1:0]   my,
  input  logic                 in_valid,
  input  logic [FLIT_W-1:0]    in_data,
  input  logic                 in_last,
  input  logic                 loc_can,
  input  logic                 st_full,
  output logic                 in_ready,
  output logic                 accept,
  output logic                 head,
  output logic                 st_wr,
  output logic [FLIT_W-1:0]    st_wdata
);
  localparam int DEST_W = 2 * COORD_W;

  logic in_pkt_q;
  logic pkt_copy_q;
  logic copy_sel;

  assign head     = !in_pkt_q;
  assign copy_sel = in_pkt_q ? pkt_copy_q : (role == pkt_fork_pkg::ROLE_MASTER);
  assign in_ready = loc_can && (!copy_sel || !st_full);
  assign accept   = in_valid && in_ready;
  assign st_wr    = accept && copy_sel;

  always_comb begin
    st_wdata = in_data;
    if (head) st_wdata[DEST_W-1:0] = {mx, my};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q   <= 1'b0;
      pkt_copy_q <= 1'b0;
    end else if (accept) begin
      in_pkt_q <= !in_last;
      if (head) pkt_copy_q <= (role == pkt_fork_pkg::ROLE_MASTER);
    end
  end
endmodule

// File: rtl/pkt_fork_out.sv
module pkt_fork_out #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         can,
  output logic         valid,
  output logic [W-1:0] q
);
  assign can = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else if (can) valid <= load;
  end

  always_ff @(posedge clk) begin
    if (can && load) q <= d;
  end
endmodule

// File: rtl/pkt_fork_store.sv
module pkt_fork_store #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [W-1:0]   wdata,
  output logic           full,
  output logic [$clog2(DEPTH):0] cnt,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [W-1:0]   out_data
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_C  = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          pop;

  assign full = (cnt == DEPTH_C);
  assign pop  = (cnt != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= wdata;
    if (pop) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr)  wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      if (pop) rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(wr) - CNT_W'(pop);
      if (pop) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_fork_top.sv
module pkt_fork_top #(
  parameter int FLIT_W  = 32,
  parameter int COORD_W = 4,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_role,
  input  logic [COORD_W-1:0] cfg_mx,
  input  logic [COORD_W-1:0] cfg_my,
  input  logic               in_valid,
  input  logic [FLIT_W-1:0]  in_data,
  input  logic               in_last,
  output logic               in_ready,
  output logic               loc_valid,
  output logic [FLIT_W-1:0]  loc_data,
  output logic               loc_last,
  input  logic               loc_ready,
  output logic               cpy_valid,
  output logic [FLIT_W-1:0]  cpy_data,
  output logic               cpy_last,
  input  logic               cpy_ready
);
  localparam int W     = FLIT_W + 1;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  pkt_fork_pkg::role_t role;
  logic [COORD_W-1:0]  mir_x;
  logic [COORD_W-1:0]  mir_y;
  logic                accept;
  logic                head_flit;
  logic                loc_can;
  logic                st_full;
  logic                st_wr;
  logic [FLIT_W-1:0]   st_wdata;
  logic [CNT_W-1:0]    st_cnt;
  logic [W-1:0]        loc_q;
  logic [W-1:0]        cpy_q;

  pkt_fork_cfg #(.COORD_W(COORD_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .role_in(cfg_role),
    .mx_in(cfg_mx), .my_in(cfg_my), .role(role), .mx(mir_x), .my(mir_y)
  );

  pkt_fork_ctrl #(.FLIT_W(FLIT_W), .COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .role(role), .mx(mir_x), .my(mir_y),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .loc_can(loc_can), .st_full(st_full), .in_ready(in_ready),
    .accept(accept), .head(head_flit), .st_wr(st_wr), .st_wdata(st_wdata)
  );

  pkt_fork_out #(.W(W)) u_loc (
    .clk(clk), .rst(rst), .load(accept), .d({in_last, in_data}),
    .ready(loc_ready), .can(loc_can), .valid(loc_valid), .q(loc_q)
  );

  pkt_fork_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr(st_wr), .wdata({in_last, st_wdata}),
    .full(st_full), .cnt(st_cnt), .out_ready(cpy_ready),
    .out_valid(cpy_valid), .out_data(cpy_q)
  );

  assign loc_data = loc_q[FLIT_W-1:0];
  assign loc_last = loc_q[FLIT_W];
  assign cpy_data = cpy_q[FLIT_W-1:0];
  assign cpy_last = cpy_q[FLIT_W];
endmodule

// File: rtl/pkt_fork_chk.sv
module pkt_fork_chk #(
  parameter int FLIT_W  = 32,
  parameter int COORD_W = 4,
  parameter int DEPTH   = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [FLIT_W-1:0]         in_data,
  input logic                      in_last,
  input logic                      loc_valid,
  input logic                      loc_ready,
  input logic [FLIT_W-1:0]         loc_data,
  input logic                      loc_last,
  input logic                      cpy_valid,
  input logic                      cpy_ready,
  input logic [FLIT_W-1:0]         cpy_data,
  input logic [$clog2(DEPTH):0]    st_cnt,
  input logic                      st_wr,
  input logic                      st_head,
  input logic [FLIT_W-1:0]         st_wdata,
  input logic [COORD_W-1:0]        mir_x,
  input logic [COORD_W-1:0]        mir_y
);
  localparam int CNT_W  = $clog2(DEPTH) + 1;
  localparam int DEST_W = 2 * COORD_W;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  assert_loc_load_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (loc_valid && loc_data == $past(in_data) && loc_last == $past(in_last)));

  assert_loc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && !loc_ready) |=> (loc_valid && $stable(loc_data)));

  assert_cpy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cpy_valid && !cpy_ready) |=> (cpy_valid && $stable(cpy_data)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    st_cnt <= DEPTH_C);

  assert_head_rewrite_R3: assert property (@(posedge clk) disable iff (rst)
    (st_wr && st_head) |-> (st_wdata[DEST_W-1:0] == {mir_x, mir_y}
                            && st_wdata[FLIT_W-1:DEST_W] == in_data[FLIT_W-1:DEST_W]));

  assert_body_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (st_wr && !st_head) |-> (st_wdata == in_data));
endmodule

bind pkt_fork_top pkt_fork_chk #(.FLIT_W(FLIT_W), .COORD_W(COORD_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_last(in_last), .loc_valid(loc_valid),
  .loc_ready(loc_ready), .loc_data(loc_data), .loc_last(loc_last),
  .cpy_valid(cpy_valid), .cpy_ready(cpy_ready), .cpy_data(cpy_data),
  .st_cnt(st_cnt), .st_wr(st_wr), .st_head(head_flit), .st_wdata(st_wdata),
  .mir_x(mir_x), .mir_y(mir_y)
);

// File: tb/sim_pkt_fork_top.sv
`timescale 1ns/1ps
module sim_pkt_fork_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [1:0]  cfg_role = 0;
  logic [3:0]  cfg_mx = 0, cfg_my = 0;
  logic        in_valid = 0;
  logic [31:0] in_data = 0;
  logic        in_last = 0;
  logic        in_ready;
  logic        loc_valid, loc_last, cpy_valid, cpy_last;
  logic [31:0] loc_data, cpy_data;
  logic        loc_ready = 1, cpy_ready = 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] mx = 0, my = 0;
  logic [32:0] loc_got[$], cpy_got[$], loc_exp[$], cpy_exp[$];
  logic [31:0] pd [64];
  logic        pl [64];

  always #2.5 clk = ~clk;

  pkt_fork_top u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_role(cfg_role),
    .cfg_mx(cfg_mx), .cfg_my(cfg_my), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .loc_valid(loc_valid),
    .loc_data(loc_data), .loc_last(loc_last), .loc_ready(loc_ready),
    .cpy_valid(cpy_valid), .cpy_data(cpy_data), .cpy_last(cpy_last),
    .cpy_ready(cpy_ready)
  );

  always @(negedge clk) begin
    if (!rst && loc_valid && loc_ready) loc_got.push_back({loc_last, loc_data});
    if (!rst && cpy_valid && cpy_ready) cpy_got.push_back({cpy_last, cpy_data});
  end

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] r, input logic [3:0] x, input logic [3:0] y);
    cfg_we = 1; cfg_role = r; cfg_mx = x; cfg_my = y;
    @(posedge clk); #1;
    cfg_we = 0;
    mx = x; my = y;
  endtask

  // fill pd/pl with an n-flit packet and append expected streams
  task automatic build(input int n, input logic [31:0] base, input bit copy);
    for (int i = 0; i < n; i++) begin
      pd[i] = base + 32'(i * 17);
      pl[i] = (i == n - 1);
      loc_exp.push_back({pl[i], pd[i]});
      if (copy) cpy_exp.push_back({pl[i], (i == 0) ? {pd[i][31:8], mx, my} : pd[i]});
    end
  endtask

  task automatic push(input logic [31:0] d, input logic l);
    in_valid = 1; in_data = d; in_last = l;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) push(pd[i], pl[i]);
  endtask

  task automatic compare(input string tag);
    repeat (40) @(posedge clk);
    #1;
    chk(loc_got.size() == loc_exp.size(), {tag, " local count"}, 33'(loc_got.size()), 33'(loc_exp.size()));
    chk(cpy_got.size() == cpy_exp.size(), {tag, " copy count"}, 33'(cpy_got.size()), 33'(cpy_exp.size()));
    for (int i = 0; i < loc_exp.size() && i < loc_got.size(); i++)
      chk(loc_got[i] == loc_exp[i], {tag, " local flit"}, loc_got[i], loc_exp[i]);
    for (int i = 0; i < cpy_exp.size() && i < cpy_got.size(); i++)
      chk(cpy_got[i] == cpy_exp[i], {tag, " copy flit"}, cpy_got[i], cpy_exp[i]);
    loc_got.delete(); cpy_got.delete(); loc_exp.delete(); cpy_exp.delete();
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(loc_valid == 0, "R1 loc_valid", 33'(loc_valid), 0);
    chk(cpy_valid == 0, "R1 cpy_valid", 33'(cpy_valid), 0);
    chk(in_ready == 1, "R1 in_ready", 33'(in_ready), 1);
    @(posedge clk); #1;
    build(2, 32'h1234_5600, 0);   // R1: reset role is normal, no copy
    send(2);
    compare("R1");
  endtask

  task automatic t_master;
    cfg_write(2'd1, 4'd3, 4'd5);
    build(3, 32'hA0B0_C077, 1); send(3);   // R3 R4
    build(1, 32'h0000_11FF, 1); send(1);
    build(5, 32'hDEAD_BE21, 1); send(5);
    compare("R2 R3 R4 master");
  endtask

  task automatic t_nocopy;
    cfg_write(2'd0, 4'd7, 4'd7);
    build(3, 32'h5555_0001, 0); send(3);
    cfg_write(2'd2, 4'd1, 4'd2);
    build(2, 32'h6666_0002, 0); send(2);
    cfg_write(2'd3, 4'd1, 4'd2);
    build(2, 32'h7777_0003, 0); send(2);
    compare("R5 no copy");
  endtask

  task automatic t_latency;
    cfg_write(2'd1, 4'd9, 4'd4);
    build(1, 32'hCAFE_0012, 1);
    in_valid = 1; in_data = pd[0]; in_last = 1;
    @(negedge clk);
    chk(in_ready == 1, "R9 ready", 33'(in_ready), 1);
    @(posedge clk); #1; in_valid = 0;
    @(negedge clk);
    chk(loc_valid == 1 && loc_data == pd[0], "R9 local after one edge", {loc_valid, loc_data}, {1'b1, pd[0]});
    chk(cpy_valid == 0, "R9 copy not yet", 33'(cpy_valid), 0);
    @(negedge clk);
    chk(cpy_valid == 1 && cpy_data == {pd[0][31:8], 4'd9, 4'd4}, "R9 copy after two edges",
        {cpy_valid, cpy_data}, {1'b1, pd[0][31:8], 4'd9, 4'd4});
    compare("R9");
  endtask

  task automatic t_loc_stall;
    cfg_write(2'd1, 4'd2, 4'd6);
    loc_ready = 0;
    build(2, 32'h0101_0033, 1);
    in_valid = 1; in_data = pd[0]; in_last = 0;
    @(negedge clk);
    chk(in_ready == 1, "R6 first ready", 33'(in_ready), 1);
    @(posedge clk); #1;
    in_data = pd[1]; in_last = 1;
    repeat (6) @(negedge clk);
    chk(in_ready == 0, "R6 stalled by local", 33'(in_ready), 0);
    chk(cpy_got.size() == 1, "R6 copy holds one flit", 33'(cpy_got.size()), 1);
    @(posedge clk); #1;
    loc_ready = 1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1; in_valid = 0;
    compare("R6");
  endtask

  task automatic t_copy_full;
    int idx;
    cfg_write(2'd1, 4'd12, 4'd1);
    cpy_ready = 0;
    build(20, 32'h3000_0044, 1);
    idx = 0;
    repeat (60) begin
      in_valid = (idx < 20); in_data = pd[idx % 20]; in_last = pl[idx % 20];
      @(negedge clk);
      if (in_valid && in_ready) idx++;
      @(posedge clk); #1;
    end
    in_valid = 0;
    chk(idx == 17, "R7 accepted before stall", 33'(idx), 17);
    @(negedge clk);
    in_valid = 1; in_data = pd[idx]; in_last = pl[idx];
    #0.1;
    chk(in_ready == 0, "R7 in_ready low when full", 33'(in_ready), 0);
    @(posedge clk); #1;
    cpy_ready = 1;
    while (idx < 20) begin
      in_valid = 1; in_data = pd[idx]; in_last = pl[idx];
      @(negedge clk);
      if (in_ready) idx++;
      @(posedge clk); #1;
    end
    in_valid = 0;
    compare("R7 no loss");
  endtask

  task automatic t_midswitch;
    cfg_write(2'd1, 4'd4, 4'd8);
    build(3, 32'h4400_0055, 1);
    push(pd[0], pl[0]);
    cfg_write(2'd0, 4'd0, 4'd0);   // R8: change while packet open
    push(pd[1], pl[1]);
    push(pd[2], pl[2]);
    build(2, 32'h4500_0066, 0); send(2);
    compare("R8 role latched");
    cfg_write(2'd1, 4'd15, 4'd14); // R10: next head follows new setting
    build(2, 32'h4600_0077, 1); send(2);
    compare("R10 write applies");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_master();
    t_nocopy();
    t_latency();
    t_loc_stall();
    t_copy_full();
    t_midswitch();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule